// File: doc/BRIEF.md
# Shifted-Operand Bit-Test Flag Unit

This block is one execute slice of a 32-bit integer pipeline. It tests a first operand against a second operand that has first been shifted by a variable amount. The shift amount comes from a third register value, and a 2-bit code picks the kind of shift. The block ANDs the shifted value with the first operand but never delivers that AND. It keeps only three condition flags derived from it: negative, zero and carry.

The carry flag comes from the shifter, not from an adder. The shifter's carry-out reflects the last bit moved out of the operand. When the shift moves nothing, the stored carry passes through unchanged, so the shifter reads the current carry flag as an input. The overflow flag is never written by a test; only reset touches it.

Flags change on a rising clock edge when the valid strobe is high, and keep their values otherwise. The amount field is a full byte, so amounts from 32 to 255 are legal and have defined results.

Top module: `tf_test_unit`

## Requirements
- R1: The shift select code picks the shift kind: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right.
- R2: Only bits [7:0] of `amt_src` form the shift amount, read as an unsigned number; bits [31:8] have no effect on any flag.
- R3: With a shift amount of 0, for every shift kind, the second operand is used unchanged and the carry flag keeps its stored value.
- R4: Logical left by n in 1..32 gives carry equal to operand bit 32-n. For n above 32 both the shifted value and the carry are 0.
- R5: Logical right by n in 1..32 gives carry equal to operand bit n-1. For n above 32 both the shifted value and the carry are 0.
- R6: Arithmetic right by n in 1..31 gives carry equal to operand bit n-1. For n of 32 or more, every bit of the shifted value and the carry equal operand bit 31.
- R7: Rotate right by a nonzero n rotates by n mod 32, and the carry equals bit 31 of the rotated value. This also holds when n is a nonzero multiple of 32.
- R8: After an accepted test, `flag_n` equals bit 31 of (op_a AND shifted op_b).
- R9: After an accepted test, `flag_z` is 1 exactly when all 32 bits of (op_a AND shifted op_b) are 0.
- R10: After an accepted test, `flag_c` equals the shifter carry-out. No test ever changes `flag_v`.
- R11: When `in_valid` is low at a rising edge, all four flags keep their values.
- R12: A synchronous active-high `rst` clears all four flags at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept the operands and update the flags at this edge |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, the one that is shifted |
| amt_src | input | 32 | Register value whose low byte is the shift amount |
| shift_sel | input | 2 | Shift kind code |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag, only cleared by reset |

## Verification
The only state is the four flag bits, so a wrong internal value shows on a flag output one clock after the strobe that caused it. A carry error also feeds back through every later zero-amount test, which passes the stored carry on. The bench therefore compares all four flags against its model after every cycle. It puts weight on amounts 0, 1, 31, 32, 33, the multiples of 32 and 255 for each shift kind, where a shifter error is most likely to show on the carry.

// File: rtl/tf_pkg.sv
package tf_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/tf_shifter.sv
module tf_shifter
  import tf_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  x,
  input  logic [AW-1:0] amt,
  input  logic [1:0]    kind,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);

  localparam int          KW    = $clog2(W);
  localparam int          CLW   = $clog2(W + 1);
  localparam logic [AW:0] W_AMT = (AW + 1)'(W);

  logic [W:0]     lsl_ext;
  logic [W:0]     lsr_ext;
  logic [W:0]     asr_ext;
  logic [2*W-1:0] ror_dbl;
  logic [CLW-1:0] asr_amt;
  logic [KW-1:0]  rot_k;
  logic           amt_zero;
  logic           amt_big;

  assign amt_zero = (amt == '0);
  assign amt_big  = ({1'b0, amt} >= W_AMT);
  assign asr_amt  = amt_big ? CLW'(W) : CLW'(amt);
  assign rot_k    = amt[KW-1:0];

  // Widened by one bit so the last bit shifted out lands in the extra position.
  assign lsl_ext = {1'b0, x} << amt;
  assign lsr_ext = {x, 1'b0} >> amt;
  assign asr_ext = W'(0) + (W + 1)'($signed({x, 1'b0}) >>> asr_amt);
  assign ror_dbl = {x, x} >> rot_k;

  always_comb begin
    res  = x;
    cout = cin;
    if (!amt_zero) begin
      unique case (shift_kind_e'(kind))
        SH_LSL: begin
          res  = lsl_ext[W-1:0];
          cout = lsl_ext[W];
        end
        SH_LSR: begin
          res  = lsr_ext[W:1];
          cout = lsr_ext[0];
        end
        SH_ASR: begin
          res  = asr_ext[W:1];
          cout = asr_ext[0];
        end
        SH_ROR: begin
          res  = ror_dbl[W-1:0];
          cout = ror_dbl[W-1];
        end
        default: begin
          res  = x;
          cout = cin;
        end
      endcase
    end
  end

endmodule

// File: rtl/tf_and_eval.sv
module tf_and_eval #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_sh,
  output logic         neg,
  output logic         zero
);

  logic [W-1:0] masked;

  assign masked = a & b_sh;
  assign neg    = masked[W-1];
  assign zero   = ~|masked;

endmodule

// File: rtl/tf_flag_reg.sv
module tf_flag_reg
  import tf_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  logic   n_in,
  input  logic   z_in,
  input  logic   c_in,
  output flags_t q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q.n <= n_in;
      q.z <= z_in;
      q.c <= c_in;
    end
  end

  // R11: flags hold when nothing is accepted
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

  // R10: a test never writes the overflow flag
  p_v_kept_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> $stable(q.v));

  // R12: reset clears every flag
  p_reset_clear_r12: assert property (@(posedge clk)
    rst |=> (q == '0));

endmodule

// File: rtl/tf_test_unit.sv
module tf_test_unit
  import tf_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] amt_src,
  input  logic [1:0]   shift_sel,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);

  logic [AW-1:0] amt;
  logic [W-1:0]  b_sh;
  logic          sh_c;
  logic          nx_n;
  logic          nx_z;
  flags_t        fl;

  assign amt = amt_src[AW-1:0];

  tf_shifter #(.W(W), .AW(AW)) u_shift (
    .x    (op_b),
    .amt  (amt),
    .kind (shift_sel),
    .cin  (fl.c),
    .res  (b_sh),
    .cout (sh_c)
  );

  tf_and_eval #(.W(W)) u_eval (
    .a    (op_a),
    .b_sh (b_sh),
    .neg  (nx_n),
    .zero (nx_z)
  );

  tf_flag_reg u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid),
    .n_in (nx_n),
    .z_in (nx_z),
    .c_in (sh_c),
    .q    (fl)
  );

  assign flag_n = fl.n;
  assign flag_z = fl.z;
  assign flag_c = fl.c;
  assign flag_v = fl.v;

  // R3: zero amount leaves the operand and the carry as they were
  p_zero_amt_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amt == '0) |=> (flag_c == $past(flag_c)));

  // R4: left shift past the width clears the carry
  p_lsl_far_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shift_sel == 2'b00 && amt > AW'(W)) |=> (!flag_c && flag_z && !flag_n));

  // R6: arithmetic shift of W or more copies the sign into the carry
  p_asr_far_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shift_sel == 2'b10 && amt >= AW'(W)) |=> (flag_c == $past(op_b[W-1])));

  // R9: negative and zero never hold together after a test
  p_nz_excl_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !(flag_n && flag_z));

  // R8: a zero first operand can never report negative
  p_n_zero_a_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_a == '0) |=> (flag_z && !flag_n));

endmodule

// File: tb/sim_tf_test_unit.sv
module sim_tf_test_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic [31:0] amt_src;
  logic [1:0]  shift_sel;
  logic        flag_n, flag_z, flag_c, flag_v;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  bit  m_n, m_z, m_c, m_v;

  always #5 clk = ~clk;

  tf_test_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .amt_src(amt_src), .shift_sel(shift_sel),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // Behavioural model: one bit per step, carry is whatever left the word last.
  task automatic ref_shift(input logic [31:0] x, input int n, input int kind,
                           input bit cin, output logic [31:0] r, output bit c);
    r = x;
    c = cin;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: begin c = r[31]; r = {r[30:0], 1'b0}; end
        1: begin c = r[0];  r = {1'b0, r[31:1]}; end
        2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endtask

  task automatic compare(input string tag);
    n_tests++;
    if ({flag_n, flag_z, flag_c, flag_v} !== {m_n, m_z, m_c, m_v}) begin
      n_fail++;
      $display("FAIL %s: nzcv actual %b%b%b%b expected %b%b%b%b", tag,
               flag_n, flag_z, flag_c, flag_v, m_n, m_z, m_c, m_v);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] s, input logic [1:0] k, input string tag);
    logic [31:0] r;
    logic [31:0] andv;
    bit          c;
    in_valid  = v;
    op_a      = a;
    op_b      = b;
    amt_src   = s;
    shift_sel = k;
    if (v) begin
      ref_shift(b, int'(s[7:0]), int'(k), m_c, r, c);
      andv = a & r;
      m_n  = andv[31];
      m_z  = (andv == 32'd0);
      m_c  = c;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    {m_n, m_z, m_c, m_v} = 4'b0000;
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; amt_src = '0; shift_sel = '0;
    {m_n, m_z, m_c, m_v} = 4'b0000;
    repeat (2) @(negedge clk);
    do_reset("R12 reset");

    // Set carry to 1 via left shift, then check zero-amount passthrough for all kinds
    step(1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 2'b00, "R4 lsl1 carry");
    for (int k = 0; k < 4; k++)
      step(1, 32'hFFFF_FFFF, 32'h0000_00F0, 32'h0000_0000, 2'(k), "R3 zero amount");
    step(1, 32'h0000_0001, 32'h0000_0001, 32'h0000_0100, 2'b00, "R2 upper bits ignored");
    step(1, 32'hFFFF_FFFF, 32'h0000_0001, 32'd32, 2'b00, "R4 lsl32");
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd33, 2'b00, "R4 lsl33");
    step(1, 32'hFFFF_FFFF, 32'h8000_0001, 32'd1, 2'b01, "R5 lsr1");
    step(1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd32, 2'b01, "R5 lsr32");
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd200, 2'b01, "R5 lsr200");
    step(1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd31, 2'b10, "R6 asr31");
    step(1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd40, 2'b10, "R6 asr40 neg");
    step(1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd255, 2'b10, "R6 asr255 pos");
    step(1, 32'hFFFF_FFFF, 32'h0000_0001, 32'd1, 2'b11, "R7 ror1");
    step(1, 32'hFFFF_FFFF, 32'h8000_0002, 32'd64, 2'b11, "R7 ror64");
    step(1, 32'hFFFF_FFFF, 32'h0000_0010, 32'd37, 2'b11, "R7 ror37");
    step(1, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'd0, 2'b00, "R9 zero result");
    step(1, 32'h8000_0000, 32'h4000_0000, 32'd1, 2'b00, "R8 negative");
    step(1, 32'h1234_5678, 32'h0000_0000, 32'hABCD_EF05, 2'b01, "R1 lsr code");
    for (int i = 0; i < 5; i++)
      step(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd3, 2'b01, "R11 hold");
    step(1, 32'h0000_0001, 32'h0000_0001, 32'd0, 2'b10, "R10 v untouched");
    do_reset("R12 mid reset");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b, s;
      a = $urandom();
      b = $urandom();
      s = $urandom();
      if (i % 3 == 0) s[7:0] = 8'(i % 70);
      if (i % 7 == 0) a = 32'hFFFF_FFFF;
      step(($urandom() % 5) != 0, a, b, s, 2'($urandom()), "R1 R10 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule